// File: doc/BRIEF.md
# Die-to-Die Boundary Wrapper Chain

This block places one wrapper cell on every signal that crosses a bond between two stacked dies. It sits between the core and the bond pads. Transmit cells carry core outputs to the pads. Receive cells carry pad values back into the core. A serial test path runs through all the cells. A test port controller outside the block drives it with shift, capture and update strobes and a two-bit mode select.

The serial path leaves the block towards the die stacked above. The path that comes back from that die becomes this die's serial output. On the top die, the upper connection is looped back. Each cell has a shift flop and a separate update flop, so driven values change only on the update strobe and never while data is shifting.

A small mode state machine sets how the cells behave. Its states are:
- WM_SYSTEM: all cells are transparent and functional signals pass unchanged.
- WM_INTEST: the core is isolated from the pads for internal test.
- WM_XDRIVE: this die drives known patterns across the bonds.
- WM_XOBSERVE: this die receives the bond values and compares them with an expected pattern held in its receive latches.

Every transition happens on the update strobe. The next state is given by the mode select value, from any state to any state. With no update strobe, every state holds. So in the interconnect test either die can be the driver, and the other die is the observer.

Top module: `d2d_wrap_chain`

## Requirements
- R1: After reset the mode is WM_SYSTEM, all update flops are 0, the mismatch vector is 0 and the fail flag is 0.
- R2: On an update strobe the mode is loaded from mode_sel, with 00 giving WM_SYSTEM, 01 giving WM_INTEST, 10 giving WM_XDRIVE and 11 giving WM_XOBSERVE. With no update strobe the mode holds, whatever mode_sel does.
- R3: In WM_SYSTEM, pad_tx equals core_out and core_in equals pad_rx, with no register in the path.
- R4: In WM_INTEST, WM_XDRIVE and WM_XOBSERVE, core_in comes from the receive update flops. It stays stable through shift and capture cycles.
- R5: In WM_INTEST, WM_XDRIVE and WM_XOBSERVE, pad_tx comes from the transmit update flops. It changes only on an update strobe, never while data is shifting.
- R6: The serial order is tdi, then transmit cells 0 to NUM_TX-1, then receive cells 0 to NUM_RX-1, then up_tdo. The chain moves one position per clock while shift_en is high. tdo follows up_tdi directly.
- R7: On capture_en, the transmit shift flops load core_out and the receive shift flops load pad_rx. Capture takes priority over shift.
- R8: A capture in WM_XOBSERVE sets mismatch[j] to pad_rx[j] XOR the receive update flop j. A capture in any other mode clears mismatch. Without a capture, mismatch holds.
- R9: fail is set when a capture produces any mismatch bit. After that it stays set until reset.
- R10: On update_en every update flop copies its shift flop.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Test and functional clock |
| rst_n | input | 1 | Active-low asynchronous reset |
| mode_sel | input | 2 | Mode code, taken on update strobe |
| shift_en | input | 1 | Shift strobe for the serial path |
| capture_en | input | 1 | Capture strobe |
| update_en | input | 1 | Update strobe (latches and mode) |
| tdi | input | 1 | Serial data from below |
| tdo | output | 1 | Serial data returned downward |
| up_tdo | output | 1 | Serial data towards the upper die |
| up_tdi | input | 1 | Serial data back from the upper die |
| core_out | input | NUM_TX | Core signals leaving through the bonds |
| pad_tx | output | NUM_TX | Values driven onto the transmit bonds |
| pad_rx | input | NUM_RX | Values received from the bonds |
| core_in | output | NUM_RX | Values presented to the core inputs |
| mismatch | output | NUM_RX | Per-bond compare result from the last capture |
| fail | output | 1 | Sticky flag for any mismatch |

## Verification
On every cycle, assertions check the following: the mode changes only on an update strobe; update flops copy the chain on update; the chain moves by one on shift; mismatch holds without a capture; fail never clears; and the isolated outputs stay stable between updates. Some behaviour can only be shown by the bench's scenarios:
- the mode decode values;
- which cell sits at which chain position;
- capture winning over shift;
- the compare result across a chosen fault pattern;
- transparency in WM_SYSTEM;
- the pass-through from the upper die.

// File: rtl/d2d_wrap_pkg.sv
package d2d_wrap_pkg;
    typedef enum logic [1:0] {
        WM_SYSTEM   = 2'b00,
        WM_INTEST   = 2'b01,
        WM_XDRIVE   = 2'b10,
        WM_XOBSERVE = 2'b11
    } wrap_mode_e;
endpackage

// File: rtl/d2d_mode_fsm.sv
module d2d_mode_fsm
    import d2d_wrap_pkg::*;
(
    input  logic       clk,
    input  logic       rst_n,
    input  logic       update_en,
    input  logic [1:0] mode_sel,
    output logic       pass_en,
    output logic       cmp_en
);
    wrap_mode_e state_q, state_d;

    always_comb begin
        state_d = state_q;
        if (update_en) begin
            unique case (mode_sel)
                2'b00:   state_d = WM_SYSTEM;
                2'b01:   state_d = WM_INTEST;
                2'b10:   state_d = WM_XDRIVE;
                default: state_d = WM_XOBSERVE;
            endcase
        end
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) state_q <= WM_SYSTEM;
        else        state_q <= state_d;
    end

    always_comb begin
        pass_en = 1'b0;
        cmp_en  = 1'b0;
        unique case (state_q)
            WM_SYSTEM:   pass_en = 1'b1;
            WM_INTEST:   ;
            WM_XDRIVE:   ;
            WM_XOBSERVE: cmp_en  = 1'b1;
            default:     ;
        endcase
    end

    // R2
    mode_hold_chk: assert property (@(posedge clk) disable iff (!rst_n)
        !update_en |=> $stable(state_q));
    // R2
    mode_load_chk: assert property (@(posedge clk) disable iff (!rst_n)
        update_en |=> (2'(state_q) == $past(mode_sel)));
endmodule

// File: rtl/d2d_bcell.sv
module d2d_bcell (
    input  logic clk,
    input  logic rst_n,
    input  logic si,
    input  logic cap_d,
    input  logic shift_en,
    input  logic capture_en,
    input  logic update_en,
    output logic sh_q,
    output logic upd_q
);
    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n)          sh_q <= 1'b0;
        else if (capture_en) sh_q <= cap_d;
        else if (shift_en)   sh_q <= si;
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n)         upd_q <= 1'b0;
        else if (update_en) upd_q <= sh_q;
    end
endmodule

// File: rtl/d2d_cell_chain.sv
module d2d_cell_chain #(
    parameter int NUM_TX = 4,
    parameter int NUM_RX = 4
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic              si,
    input  logic              shift_en,
    input  logic              capture_en,
    input  logic              update_en,
    input  logic [NUM_TX-1:0] core_out,
    input  logic [NUM_RX-1:0] pad_rx,
    output logic [NUM_TX-1:0] tx_upd,
    output logic [NUM_RX-1:0] rx_upd,
    output logic              so
);
    localparam int LEN = NUM_TX + NUM_RX;

    logic [LEN-1:0] sh_v, upd_v, cap_v, si_v;

    assign cap_v = {pad_rx, core_out};
    assign si_v  = {sh_v[LEN-2:0], si};

    for (genvar k = 0; k < LEN; k++) begin : g_cell
        d2d_bcell u_cell (
            .clk        (clk),
            .rst_n      (rst_n),
            .si         (si_v[k]),
            .cap_d      (cap_v[k]),
            .shift_en   (shift_en),
            .capture_en (capture_en),
            .update_en  (update_en),
            .sh_q       (sh_v[k]),
            .upd_q      (upd_v[k])
        );
    end

    assign tx_upd = upd_v[NUM_TX-1:0];
    assign rx_upd = upd_v[LEN-1:NUM_TX];
    assign so     = sh_v[LEN-1];

    // R6
    shift_step_chk: assert property (@(posedge clk) disable iff (!rst_n)
        (shift_en && !capture_en) |=> (sh_v[0] == $past(si)));
    // R10
    update_copy_chk: assert property (@(posedge clk) disable iff (!rst_n)
        update_en |=> (upd_v == $past(sh_v)));
    // R10
    upd_hold_chk: assert property (@(posedge clk) disable iff (!rst_n)
        !update_en |=> $stable(upd_v));
endmodule

// File: rtl/d2d_rx_compare.sv
module d2d_rx_compare #(
    parameter int NUM_RX = 4
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic              capture_en,
    input  logic              cmp_en,
    input  logic [NUM_RX-1:0] pad_rx,
    input  logic [NUM_RX-1:0] expect_rx,
    output logic [NUM_RX-1:0] mismatch,
    output logic              fail
);
    logic [NUM_RX-1:0] diff;
    assign diff = cmp_en ? (pad_rx ^ expect_rx) : '0;

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            mismatch <= '0;
            fail     <= 1'b0;
        end else if (capture_en) begin
            mismatch <= diff;
            if (|diff) fail <= 1'b1;
        end
    end

    // R8
    mism_hold_chk: assert property (@(posedge clk) disable iff (!rst_n)
        !capture_en |=> $stable(mismatch));
    // R9
    fail_sticky_chk: assert property (@(posedge clk) disable iff (!rst_n)
        fail |=> fail);
    // R9
    mism_fail_chk: assert property (@(posedge clk) disable iff (!rst_n)
        (|mismatch) |-> fail);
endmodule

// File: rtl/d2d_wrap_chain.sv
module d2d_wrap_chain #(
    parameter int NUM_TX = 4,
    parameter int NUM_RX = 4
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic [1:0]        mode_sel,
    input  logic              shift_en,
    input  logic              capture_en,
    input  logic              update_en,
    input  logic              tdi,
    output logic              tdo,
    output logic              up_tdo,
    input  logic              up_tdi,
    input  logic [NUM_TX-1:0] core_out,
    output logic [NUM_TX-1:0] pad_tx,
    input  logic [NUM_RX-1:0] pad_rx,
    output logic [NUM_RX-1:0] core_in,
    output logic [NUM_RX-1:0] mismatch,
    output logic              fail
);
    logic              pass_en, cmp_en;
    logic [NUM_TX-1:0] tx_upd;
    logic [NUM_RX-1:0] rx_upd;

    d2d_mode_fsm u_fsm (
        .clk       (clk),
        .rst_n     (rst_n),
        .update_en (update_en),
        .mode_sel  (mode_sel),
        .pass_en   (pass_en),
        .cmp_en    (cmp_en)
    );

    d2d_cell_chain #(.NUM_TX(NUM_TX), .NUM_RX(NUM_RX)) u_chain (
        .clk        (clk),
        .rst_n      (rst_n),
        .si         (tdi),
        .shift_en   (shift_en),
        .capture_en (capture_en),
        .update_en  (update_en),
        .core_out   (core_out),
        .pad_rx     (pad_rx),
        .tx_upd     (tx_upd),
        .rx_upd     (rx_upd),
        .so         (up_tdo)
    );

    d2d_rx_compare #(.NUM_RX(NUM_RX)) u_cmp (
        .clk        (clk),
        .rst_n      (rst_n),
        .capture_en (capture_en),
        .cmp_en     (cmp_en),
        .pad_rx     (pad_rx),
        .expect_rx  (rx_upd),
        .mismatch   (mismatch),
        .fail       (fail)
    );

    assign pad_tx  = pass_en ? core_out : tx_upd;
    assign core_in = pass_en ? pad_rx   : rx_upd;
    assign tdo     = up_tdi;

    // R5
    tx_quiet_chk: assert property (@(posedge clk) disable iff (!rst_n)
        (!pass_en && !update_en) |=> $stable(pad_tx));
    // R4
    rx_quiet_chk: assert property (@(posedge clk) disable iff (!rst_n)
        (!pass_en && !update_en) |=> $stable(core_in));
endmodule

// File: tb/tb_d2d_wrap_chain.sv
module tb_d2d_wrap_chain;
    localparam int NTX = 4;
    localparam int NRX = 4;
    localparam int LEN = NTX + NRX;

    logic clk = 1'b0;
    logic rst_n = 1'b0;
    logic [1:0] mode_sel = 2'b00;
    logic shift_en = 1'b0, capture_en = 1'b0, update_en = 1'b0, tdi = 1'b0;
    logic tdo, up_tdo, up_tdi;
    logic loop_en = 1'b1, up_force = 1'b0;
    logic [NTX-1:0] core_out = '0, pad_tx;
    logic [NRX-1:0] pad_rx = '0, core_in, mismatch;
    logic fail;
    int n_chk = 0, n_bad = 0;
    bit done = 1'b0;

    always #5 clk = ~clk;
    assign up_tdi = loop_en ? up_tdo : up_force;

    d2d_wrap_chain #(.NUM_TX(NTX), .NUM_RX(NRX)) dut (
        .clk(clk), .rst_n(rst_n), .mode_sel(mode_sel), .shift_en(shift_en),
        .capture_en(capture_en), .update_en(update_en), .tdi(tdi), .tdo(tdo),
        .up_tdo(up_tdo), .up_tdi(up_tdi), .core_out(core_out), .pad_tx(pad_tx),
        .pad_rx(pad_rx), .core_in(core_in), .mismatch(mismatch), .fail(fail));

    // mode(2) tx(4) rx(4) core(4) pad(4) exp_tx(4) exp_in(4) exp_mm(4) exp_fail(1)
    localparam logic [30:0] TBL [0:4] = '{
        {2'b00, 4'hA, 4'h5, 4'h3, 4'hC, 4'h3, 4'hC, 4'h0, 1'b0},
        {2'b01, 4'hA, 4'h5, 4'h3, 4'hC, 4'hA, 4'h5, 4'h0, 1'b0},
        {2'b10, 4'h6, 4'h9, 4'hF, 4'h0, 4'h6, 4'h9, 4'h0, 1'b0},
        {2'b11, 4'h1, 4'hB, 4'h0, 4'hB, 4'h1, 4'hB, 4'h0, 1'b0},
        {2'b11, 4'h0, 4'hB, 4'h0, 4'h9, 4'h0, 4'hB, 4'h2, 1'b1}
    };

    task automatic chk(input string req, input logic [7:0] act, input logic [7:0] exp);
        n_chk++;
        if (act !== exp) begin
            n_bad++;
            $display("FAIL %s: actual %h expected %h", req, act, exp);
        end
    endtask

    task automatic shift_io(input logic [LEN-1:0] v, output logic [LEN-1:0] r);
        for (int i = 0; i < LEN; i++) begin
            @(negedge clk);
            r[LEN-1-i] = tdo;
            tdi = v[LEN-1-i];
            shift_en = 1'b1;
        end
        @(negedge clk);
        shift_en = 1'b0;
    endtask

    task automatic do_update(input logic [1:0] m);
        @(negedge clk);
        mode_sel = m;
        update_en = 1'b1;
        @(negedge clk);
        update_en = 1'b0;
    endtask

    task automatic do_capture();
        @(negedge clk);
        capture_en = 1'b1;
        @(negedge clk);
        capture_en = 1'b0;
    endtask

    task automatic finish_run();
        $display("*** SUMMARY: %0d compared / %0d mismatched ***", n_chk, n_bad);
        $finish;
    endtask

    initial begin
        repeat (20000) @(posedge clk);
        if (!done) begin
            n_chk++;
            n_bad++;
            $display("FAIL watchdog: actual timeout expected completion");
            finish_run();
        end
    end

    initial begin
        logic [LEN-1:0] rd;
        logic [30:0] e;
        repeat (3) @(negedge clk);
        core_out = 4'h5;
        pad_rx = 4'hA;
        #1;
        // R1 / R3: reset state is transparent with clear flags
        chk("R1 pad_tx", 8'(pad_tx), 8'h05);
        chk("R1 core_in", 8'(core_in), 8'h0A);
        chk("R1 mismatch", 8'(mismatch), 8'h00);
        chk("R1 fail", 8'(fail), 8'h00);
        @(negedge clk);
        rst_n = 1'b1;
        @(negedge clk);
        chk("R3 pad_tx after reset", 8'(pad_tx), 8'h05);

        for (int t = 0; t < 5; t++) begin
            e = TBL[t];
            shift_io({e[24:21], e[28:25]}, rd);
            do_update(e[30:29]);
            core_out = e[20:17];
            pad_rx = e[16:13];
            @(negedge clk);
            chk("R2/R3/R4/R5 pad_tx", 8'(pad_tx), 8'(e[12:9]));
            chk("R2/R3/R4 core_in", 8'(core_in), 8'(e[8:5]));
            do_capture();
            chk("R8 mismatch", 8'(mismatch), 8'(e[4:1]));
            chk("R9 fail", 8'(fail), 8'(e[0]));
        end

        // R7: captured data from the last row reads out as {pad_rx, core_out}
        shift_io('0, rd);
        chk("R7 capture readout", rd, 8'h90);

        // R9: a matching capture clears mismatch but fail stays
        pad_rx = 4'hB;
        do_capture();
        chk("R8 match clears mismatch", 8'(mismatch), 8'h00);
        chk("R9 fail sticky", 8'(fail), 8'h01);

        // R7: capture wins over a simultaneous shift
        core_out = 4'h7;
        pad_rx = 4'h2;
        @(negedge clk);
        capture_en = 1'b1;
        shift_en = 1'b1;
        tdi = 1'b1;
        @(negedge clk);
        capture_en = 1'b0;
        shift_en = 1'b0;
        shift_io('0, rd);
        chk("R7 capture priority", rd, 8'h27);

        // R6: chain order, tx cell 0 first and rx cell 3 last
        shift_io(8'h01, rd);
        do_update(2'b01);
        @(negedge clk);
        chk("R6 tx0 position", 8'(pad_tx), 8'h01);
        chk("R6 rx side clear", 8'(core_in), 8'h00);
        shift_io(8'h80, rd);
        do_update(2'b01);
        @(negedge clk);
        chk("R6 rx3 position", 8'(core_in), 8'h08);

        // R5 / R4 / R10: shifting leaves driven values alone until update
        shift_io(8'h06, rd);
        do_update(2'b10);
        shift_io(8'hFF, rd);
        chk("R5 pad_tx quiet during shift", 8'(pad_tx), 8'h06);
        chk("R4 core_in quiet during shift", 8'(core_in), 8'h00);
        do_update(2'b10);
        @(negedge clk);
        chk("R10 update pad_tx", 8'(pad_tx), 8'h0F);
        chk("R10 update core_in", 8'(core_in), 8'h0F);

        // R2: mode_sel alone does not change the mode
        mode_sel = 2'b00;
        core_out = 4'h1;
        repeat (3) @(negedge clk);
        chk("R2 mode holds", 8'(pad_tx), 8'h0F);
        do_update(2'b00);
        @(negedge clk);
        chk("R3 back to system", 8'(pad_tx), 8'h01);

        // R6: tdo follows the upper die return path
        loop_en = 1'b0;
        up_force = 1'b1;
        #1;
        chk("R6 passthrough 1", 8'(tdo), 8'h01);
        up_force = 1'b0;
        #1;
        chk("R6 passthrough 0", 8'(tdo), 8'h00);

        done = 1'b1;
        finish_run();
    end
endmodule